// File: doc/BRIEF.md
# Half-Duplex Serial Register Read Master

This block sits on the host side of a two-wire synchronous link and fetches one 8-bit register from a peripheral. The link has one clock line, driven by the host, and one shared data line. The block derives the serial clock from the system clock. It shifts out a read-direction bit and a 7-bit register address, then lets go of the data line. It holds the clock high for a long preparation interval so that the peripheral can fetch the value. It then clocks in the eight returned bits.

A request is a single-cycle `start` with `addr` valid. `busy` covers the whole transaction. `done` pulses for one cycle with `rdata` valid. The data pad is built from `sdio_out`, `sdio_oe` and `sdio_in`. While `pwr_down` is high, no transaction is launched. Both the half period of the serial clock and the preparation interval are parameters counted in system clock cycles.

Top module: `hdx_reg_reader`

## Requirements
- R1: After reset, `sclk` is 1, `sdio_oe` is 0, `busy` is 0 and `done` is 0. Outside a transaction, `sclk` stays 1.
- R2: A `start` seen while idle and with `pwr_down` low raises `busy` in the next cycle. The transaction produces exactly 16 rising edges of `sclk`.
- R3: The first 8 rising edges sample `sdio_out` with `sdio_oe` at 1. In order, the values are a 0 direction bit and then address bits 6 down to 0. The host changes `sdio_out` only together with a falling edge of `sclk`.
- R4: `sdio_oe` goes to 0 after the 8th rising edge and before the next falling edge. It stays 0 at every later edge of the transaction.
- R5: The high phase that follows the 8th rising edge lasts exactly HALF_CYC + GAP_CYC system cycles.
- R6: Rising edges 9 to 16 sample `sdio_in` as data bits 7 down to 0. `rdata` then equals that byte.
- R7: Every other low or high phase of `sclk` inside a transaction lasts exactly HALF_CYC system cycles.
- R8: `done` is high for exactly one cycle. In that cycle `busy` is 0. `busy` never falls without `done`. `rdata` holds its value until the next `done`.
- R9: A `start` while `busy` is 1 is ignored. The running address is unchanged and no extra transaction follows.
- R10: A `start` while `pwr_down` is 1 is ignored. `busy` stays 0 and `sclk` stays 1.
- R11: A `start` in the same cycle that `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| addr | input | 7 | Register address |
| pwr_down | input | 1 | Peripheral power-down; blocks new requests |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read back |
| sclk | output | 1 | Serial clock, idles high |
| sdio_out | output | 1 | Data line value when driving |
| sdio_oe | output | 1 | Data pad output enable |
| sdio_in | input | 1 | Data line value seen at the pad |

## Verification
Two functions can land in the same cycle: completion of one read (the `done` pulse, with `busy` already low) and acceptance of the next request. The bench raises `start` in the cycle in which it sees `done`. It expects `busy` to be back at 1 one cycle later, and the second read to return its own address's data. A related collision is `start` arriving together with a high `pwr_down`. There the bench expects the idle state to persist for many cycles.

// File: rtl/hdx_reg_reader.sv
module hdx_reg_reader #(
  parameter int HALF_CYC = 13,
  parameter int GAP_CYC  = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] addr,
  input  logic       pwr_down,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       sclk,
  output logic       sdio_out,
  output logic       sdio_oe,
  input  logic       sdio_in
);
  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_GAP, S_DATA} st_t;

  st_t         st;
  logic [HW-1:0] hcnt;
  logic [GW-1:0] gcnt;
  logic [2:0]  bcnt;
  logic [7:0]  sh;

  wire ph_end = hcnt == HW'(HALF_CYC - 1);
  wire gap_end = gcnt == GW'(GAP_CYC - 1);
  wire go = start && !pwr_down && st == S_IDLE;

  assign busy = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sclk     <= 1'b1;
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      hcnt     <= '0;
      gcnt     <= '0;
      bcnt     <= '0;
      sh       <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st       <= S_ADDR;
          sclk     <= 1'b0;
          sdio_out <= 1'b0;
          sdio_oe  <= 1'b1;
          sh       <= {addr, 1'b0};
          hcnt     <= '0;
          bcnt     <= '0;
        end
        S_ADDR: if (ph_end) begin
          hcnt <= '0;
          if (!sclk) sclk <= 1'b1;
          else if (bcnt == 3'd7) begin
            st      <= S_GAP;
            sdio_oe <= 1'b0;
            gcnt    <= '0;
          end else begin
            sclk     <= 1'b0;
            sdio_out <= sh[7];
            sh       <= {sh[6:0], 1'b0};
            bcnt     <= bcnt + 3'd1;
          end
        end else hcnt <= hcnt + 1'b1;
        S_GAP: if (gap_end) begin
          st   <= S_DATA;
          sclk <= 1'b0;
          hcnt <= '0;
          bcnt <= '0;
        end else gcnt <= gcnt + 1'b1;
        S_DATA: if (ph_end) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            sh   <= {sh[6:0], sdio_in};
          end else if (bcnt == 3'd7) begin
            st    <= S_IDLE;
            done  <= 1'b1;
            rdata <= sh;
          end else begin
            sclk <= 1'b0;
            bcnt <= bcnt + 3'd1;
          end
        end else hcnt <= hcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_reg_reader_chk.sv
module hdx_reg_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [6:0] addr,
  input logic       pwr_down,
  input logic       busy,
  input logic       done,
  input logic [7:0] rdata,
  input logic       sclk,
  input logic       sdio_out,
  input logic       sdio_oe,
  input logic       sdio_in
);
  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk); // R1
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) sdio_oe |-> busy); // R4
  AST_OUT_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) (sdio_oe && $past(sdio_oe) && !$stable(sdio_out)) |-> $fell(sclk)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(rdata)); // R8
  AST_PD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n) (pwr_down && !busy) |=> !busy); // R10
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && !pwr_down && !busy) |=> busy); // R2
endmodule

bind hdx_reg_reader hdx_reg_reader_chk u_chk (.*);

// File: tb/hdx_reg_reader_test.sv
module hdx_reg_reader_test;
  localparam int HALF = 4;
  localparam int GAP  = 200;
  localparam logic [14:0] VEC [0:7] = '{15'h0080, 15'h7F7F, 15'h5555, 15'h2AAA,
                                        15'h0101, 15'h40C0, 15'h3333, 15'h0C8C};

  logic clk = 0, rst_n = 0, start = 0, pwr_down = 0, sdio_in = 0;
  logic [6:0] addr = 0;
  logic busy, done, sclk, sdio_out, sdio_oe;
  logic [7:0] rdata;
  int checks = 0, errors = 0, cyc = 0;

  hdx_reg_reader #(.HALF_CYC(HALF), .GAP_CYC(GAP)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] periph(input logic [6:0] a);
    return {~a[0], a};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic prev_s = 1, prev_b = 0;
  int run = 0, rises = 0, falls = 0;
  logic [7:0] cap = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_s = 1; prev_b = 0; run = 0; rises = 0; falls = 0;
    end else begin
      if (busy && !prev_b) begin rises = 0; falls = 0; end
      if (sclk != prev_s) begin
        if (!prev_s) begin
          chk(run == HALF, "R7 low phase", run, HALF);
          if (rises < 8) begin
            cap = {cap[6:0], sdio_out};
            chk(sdio_oe == 1, "R3 oe at address rise", sdio_oe, 1);
          end else chk(sdio_oe == 0, "R4 oe at data rise", sdio_oe, 0);
          rises++;
        end else begin
          if (rises == 8) begin
            chk(run == HALF + GAP, "R5 gap length", run, HALF + GAP);
            chk(sdio_oe == 0, "R4 oe released", sdio_oe, 1'b0);
          end else if (rises > 0) chk(run == HALF, "R7 high phase", run, HALF);
          if (falls >= 8) sdio_in = periph(cap[6:0])[15 - falls];
          falls++;
        end
        run = 1;
        prev_s = sclk;
      end else run++;
      prev_b = busy;
    end
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic fire(input logic [6:0] a);
    addr = a; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk(sclk == 1, "R1 sclk", sclk, 1);
    chk(sdio_oe == 0, "R1 oe", sdio_oe, 0);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      fire(VEC[v][14:8]);
      chk(busy == 1, "R2 busy after start", busy, 1);
      wait_done(seen);
      chk(seen, "R8 done seen", seen, 1);
      chk(busy == 0, "R8 busy low with done", busy, 0);
      chk(rdata == VEC[v][7:0], "R6 read data", rdata, VEC[v][7:0]);
      chk(cap == {1'b0, VEC[v][14:8]}, "R3 address byte", cap, {1'b0, VEC[v][14:8]});
      chk(rises == 16, "R2 rising edges", rises, 16);
      @(negedge clk);
      chk(done == 0, "R8 done width", done, 0);
      repeat (5) @(negedge clk);
      chk(rdata == VEC[v][7:0] && sclk == 1, "R8 rdata hold / R1 idle", rdata, VEC[v][7:0]);
    end

    pwr_down = 1;
    fire(7'h22);
    repeat (30) @(negedge clk);
    chk(busy == 0, "R10 no start in power-down", busy, 0);
    chk(sclk == 1 && sdio_oe == 0, "R10 link idle", {sclk, sdio_oe}, 2'b10);
    pwr_down = 0;
    @(negedge clk);

    fire(7'h15);
    repeat (20) @(negedge clk);
    fire(7'h6A);
    wait_done(seen);
    chk(rdata == periph(7'h15), "R9 data of first request", rdata, periph(7'h15));
    chk(cap[6:0] == 7'h15, "R9 address unchanged", cap[6:0], 7'h15);
    repeat (40) @(negedge clk);
    chk(busy == 0, "R9 no queued transaction", busy, 0);

    fire(7'h12);
    wait_done(seen);
    chk(rdata == periph(7'h12), "R6 first of pair", rdata, periph(7'h12));
    addr = 7'h71; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R11 start in done cycle", busy, 1);
    wait_done(seen);
    chk(rdata == periph(7'h71), "R11 second of pair", rdata, periph(7'h71));
    chk(cap == {1'b0, 7'h71}, "R11 address sent", cap, {1'b0, 7'h71});

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule